// File: doc/BRIEF.md
# Packed Float Compare Mask Unit

This unit compares two 128-bit vectors lane by lane. Each vector holds four single-precision floating-point values, with lane k in bits [32k+31:32k]. A 3-bit predicate code selects the comparison. Each lane writes an all-ones word when its comparison holds and an all-zeros word when it does not. The resulting vector can be used directly as a select mask by later vector logic.

Two exception flags come with the mask: invalid and denormal. Each flag is the OR of the per-lane conditions across all four lanes. The inputs are captured on a cycle where `in_valid` is high. The mask and flags appear one clock later, together with `out_valid`.

The unit has no greater-than style predicates of its own. The caller gets greater-than, greater-or-equal, not-greater-than and not-greater-or-equal by swapping the two operands. It then applies LT, LE, NLT or NLE.

Top module: `vec_fcmp_mask`

## Requirements
- R1: Each of the four 32-bit lanes is compared on its own. A true lane sets its result word to 32'hFFFFFFFF and a false lane sets it to 32'h00000000, whatever the other lanes do.
- R2: With predicate code 0 (EQ), a lane is true when both operands are equal and neither is NaN. +0 and -0 count as equal.
- R3: Code 1 (LT) and code 2 (LE) order non-NaN values by real value. A negative value with the larger magnitude is the smaller value, and infinities sit at the two ends. Swapping the operands gives the greater-than forms.
- R4: A lane in which either operand is NaN is unordered. Such a lane is false for EQ, LT, LE and ORD (code 7), and true for NEQ (code 4), NLT (code 5), NLE (code 6) and UNORD (code 3).
- R5: Code 7 (ORD) is true when neither lane operand is NaN. Code 3 (UNORD) is true when at least one is NaN.
- R6: `flag_invalid` is set when any lane operand is a signaling NaN (exponent all ones, fraction bit 22 clear, fraction nonzero), under every predicate.
- R7: A quiet NaN (exponent all ones, fraction bit 22 set) sets `flag_invalid` only under LT, LE, NLT and NLE. Under EQ, NEQ, ORD and UNORD it leaves the flag clear.
- R8: `flag_denorm` is set when any lane operand has a zero exponent and a nonzero fraction.
- R9: The mask and flags for inputs presented with `in_valid` high appear one cycle later, with `out_valid` high for exactly that cycle. When `in_valid` is low, `out_valid` falls and the mask and flags hold their last values.
- R10: While `rst_n` is low at a clock edge, `out_valid`, `mask`, `flag_invalid` and `flag_denorm` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and predicate are valid this cycle |
| opa | input | 128 | First operand, four single-precision lanes |
| opb | input | 128 | Second operand, four single-precision lanes |
| pred | input | 3 | Predicate code: 0 EQ, 1 LT, 2 LE, 3 UNORD, 4 NEQ, 5 NLT, 6 NLE, 7 ORD |
| out_valid | output | 1 | Result registers updated on the previous edge |
| mask | output | 128 | Per-lane all-ones or all-zeros comparison result |
| flag_invalid | output | 1 | Invalid-operation flag, OR of all lanes |
| flag_denorm | output | 1 | Denormal-operand flag, OR of all lanes |

## Verification
The hardest situations to reach are lanes that mix classes within one vector. Examples are a quiet NaN beside a signed zero pair, or a signaling NaN in one lane under a predicate that is otherwise quiet. Uniform random 32-bit words almost never produce NaNs, zeros or denormals. The random stimulus therefore draws each lane from a weighted menu of special classes (both zeros, both NaN kinds, denormals, infinities, normals). It often copies or sign-flips one operand into the other to produce equal and near-equal pairs. Directed vectors pin down the zero-sign, NaN-kind and predicate-quietness corners with hand-written expected masks.

// File: rtl/vfcm_pkg.sv
// Package: shared predicate codes and lane classification record for the
// packed compare unit. Assumes the predicate encoding is fixed at 3 bits.
package vfcm_pkg;

    localparam int PRED_W = 3;

    typedef enum logic [PRED_W-1:0] {
        PRED_EQ    = 3'd0,
        PRED_LT    = 3'd1,
        PRED_LE    = 3'd2,
        PRED_UNORD = 3'd3,
        PRED_NEQ   = 3'd4,
        PRED_NLT   = 3'd5,
        PRED_NLE   = 3'd6,
        PRED_ORD   = 3'd7
    } pred_e;

    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_denorm;
        logic is_nan;
        logic is_qnan;
        logic is_snan;
    } fclass_t;

endpackage

// File: rtl/vfcm_classify.sv
// Module: vfcm_classify
// Splits one floating-point word into sign and magnitude and classifies it
// (zero, denormal, quiet or signaling NaN). Assumes the top fraction bit is
// the quiet bit. Purely combinational.
module vfcm_classify
    import vfcm_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0]   val_i,
    output fclass_t                cls_o,
    output logic [EXP_W+MAN_W-1:0] mag_o
);
    localparam int MAG_W = EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_ones;
    logic             exp_zero;
    logic             man_nz;

    // field extraction
    assign exp_f    = val_i[MAG_W-1 -: EXP_W];
    assign man_f    = val_i[MAN_W-1:0];
    assign exp_ones = &exp_f;
    assign exp_zero = ~|exp_f;
    assign man_nz   = |man_f;
    assign mag_o    = val_i[MAG_W-1:0];

    // class decode
    always_comb begin
        cls_o.sign      = val_i[MAG_W];
        cls_o.is_zero   = exp_zero & ~man_nz;
        cls_o.is_denorm = exp_zero & man_nz;
        cls_o.is_nan    = exp_ones & man_nz;
        cls_o.is_qnan   = exp_ones & man_f[MAN_W-1];
        cls_o.is_snan   = exp_ones & man_nz & ~man_f[MAN_W-1];
    end

endmodule

// File: rtl/vfcm_lane.sv
// Module: vfcm_lane
// Compares one lane pair under the selected predicate and produces the
// lane hit bit plus the lane's invalid and denormal conditions.
// Assumes sign-magnitude encoding; combinational only.
module vfcm_lane
    import vfcm_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] a_i,
    input  logic [EXP_W+MAN_W:0] b_i,
    input  logic [PRED_W-1:0]    pred_i,
    output logic                 hit_o,
    output logic                 inv_o,
    output logic                 den_o
);
    localparam int MAG_W = EXP_W + MAN_W;

    fclass_t          ca, cb;
    logic [MAG_W-1:0] mag_a, mag_b;
    pred_e            pcode;
    logic             unord, both_zero, eq, lt, sig_pred;

    vfcm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
        .val_i (a_i),
        .cls_o (ca),
        .mag_o (mag_a)
    );

    vfcm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
        .val_i (b_i),
        .cls_o (cb),
        .mag_o (mag_b)
    );

    // relation terms shared by all predicates
    assign pcode     = pred_e'(pred_i);
    assign unord     = ca.is_nan | cb.is_nan;
    assign both_zero = ca.is_zero & cb.is_zero;
    assign eq        = both_zero | (a_i == b_i);

    // sign-magnitude less-than for non-NaN operands
    always_comb begin
        if (both_zero)
            lt = 1'b0;
        else if (ca.sign != cb.sign)
            lt = ca.sign;
        else if (!ca.sign)
            lt = (mag_a < mag_b);
        else
            lt = (mag_a > mag_b);
    end

    // predicate select
    always_comb begin
        case (pcode)
            PRED_EQ:    hit_o = ~unord & eq;
            PRED_LT:    hit_o = ~unord & lt;
            PRED_LE:    hit_o = ~unord & (lt | eq);
            PRED_UNORD: hit_o = unord;
            PRED_NEQ:   hit_o = unord | ~eq;
            PRED_NLT:   hit_o = unord | ~lt;
            PRED_NLE:   hit_o = unord | ~(lt | eq);
            default:    hit_o = ~unord;
        endcase
    end

    // ordering predicates are the ones that trap on quiet NaN
    assign sig_pred = (pcode == PRED_LT)  | (pcode == PRED_LE) |
                      (pcode == PRED_NLT) | (pcode == PRED_NLE);
    assign inv_o    = ca.is_snan | cb.is_snan |
                      ((ca.is_qnan | cb.is_qnan) & sig_pred);
    assign den_o    = ca.is_denorm | cb.is_denorm;

endmodule

// File: rtl/vec_fcmp_mask.sv
// Module: vec_fcmp_mask (top)
// Packed floating-point compare: LANES parallel lane comparators, mask
// expansion, flag OR-reduction and a single output register stage.
// Assumes a synchronous active-low reset; one result per in_valid.
module vec_fcmp_mask
    import vfcm_pkg::*;
#(
    parameter int LANES = 4,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [LANES*(EXP_W+MAN_W+1)-1:0]   opa,
    input  logic [LANES*(EXP_W+MAN_W+1)-1:0]   opb,
    input  logic [PRED_W-1:0]                  pred,
    output logic                               out_valid,
    output logic [LANES*(EXP_W+MAN_W+1)-1:0]   mask,
    output logic                               flag_invalid,
    output logic                               flag_denorm
);
    localparam int FW = EXP_W + MAN_W + 1;
    localparam int VW = LANES * FW;

    logic [LANES-1:0] hit, inv, den;
    logic [VW-1:0]    mask_d;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vfcm_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_lane (
            .a_i    (opa[l*FW +: FW]),
            .b_i    (opb[l*FW +: FW]),
            .pred_i (pred),
            .hit_o  (hit[l]),
            .inv_o  (inv[l]),
            .den_o  (den[l])
        );
        // widen the lane hit into a full-word mask
        assign mask_d[l*FW +: FW] = {FW{hit[l]}};
    end

    // output stage: capture on in_valid, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            mask         <= '0;
            flag_invalid <= 1'b0;
            flag_denorm  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                mask         <= mask_d;
                flag_invalid <= |inv;
                flag_denorm  <= |den;
            end
        end
    end

endmodule

// File: rtl/vfcm_checker.sv
// Module: vfcm_checker
// Property checker bound to vec_fcmp_mask. Classifies operands on its own
// and checks timing, mask shape and flag rules at the ports.
module vfcm_checker #(
    parameter int LANES = 4,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             in_valid,
    input logic [LANES*(EXP_W+MAN_W+1)-1:0] opa,
    input logic [LANES*(EXP_W+MAN_W+1)-1:0] opb,
    input logic [2:0]                       pred,
    input logic                             out_valid,
    input logic [LANES*(EXP_W+MAN_W+1)-1:0] mask,
    input logic                             flag_invalid,
    input logic                             flag_denorm
);
    localparam int FW = EXP_W + MAN_W + 1;

    logic snan_seen, den_seen, lanes_whole, quiet_pred;

    function automatic logic w_snan(input logic [FW-1:0] w);
        return (&w[FW-2 -: EXP_W]) && !w[MAN_W-1] && (|w[MAN_W-1:0]);
    endfunction

    function automatic logic w_den(input logic [FW-1:0] w);
        return (w[FW-2 -: EXP_W] == '0) && (|w[MAN_W-1:0]);
    endfunction

    // operand scan and mask shape scan
    always_comb begin
        snan_seen   = 1'b0;
        den_seen    = 1'b0;
        lanes_whole = 1'b1;
        for (int l = 0; l < LANES; l++) begin
            snan_seen = snan_seen | w_snan(opa[l*FW +: FW]) | w_snan(opb[l*FW +: FW]);
            den_seen  = den_seen  | w_den(opa[l*FW +: FW])  | w_den(opb[l*FW +: FW]);
            if (mask[l*FW +: FW] != '0 && mask[l*FW +: FW] != '1)
                lanes_whole = 1'b0;
        end
    end

    assign quiet_pred = (pred == 3'd0) || (pred == 3'd3) || (pred == 3'd4) || (pred == 3'd7);

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(mask) && $stable(flag_invalid) && $stable(flag_denorm)));

    assert_lane_whole_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> lanes_whole);

    assert_snan_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && snan_seen) |=> flag_invalid);

    assert_quiet_pred_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !snan_seen && quiet_pred) |=> !flag_invalid);

    assert_denorm_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (flag_denorm == $past(den_seen)));

endmodule

bind vec_fcmp_mask vfcm_checker #(.LANES(LANES), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .opa          (opa),
    .opb          (opb),
    .pred         (pred),
    .out_valid    (out_valid),
    .mask         (mask),
    .flag_invalid (flag_invalid),
    .flag_denorm  (flag_denorm)
);

// File: tb/vec_fcmp_mask_tb.sv
`timescale 1ns/1ps
// Testbench: directed corner vectors with hand-written expected results,
// then weighted random vectors checked against a key-based reference model.
module vec_fcmp_mask_tb;

    localparam logic [31:0] PZ   = 32'h0000_0000;
    localparam logic [31:0] NZ   = 32'h8000_0000;
    localparam logic [31:0] ONE  = 32'h3F80_0000;
    localparam logic [31:0] NONE = 32'hBF80_0000;
    localparam logic [31:0] TWO  = 32'h4000_0000;
    localparam logic [31:0] QN   = 32'h7FC0_0000;
    localparam logic [31:0] SN   = 32'h7F80_0001;
    localparam logic [31:0] DEN  = 32'h0000_0001;
    localparam logic [31:0] NDEN = 32'h8000_0001;
    localparam logic [31:0] PINF = 32'h7F80_0000;
    localparam logic [31:0] NINF = 32'hFF80_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] opa = '0, opb = '0;
    logic [2:0]   pred = '0;
    logic         out_valid, flag_invalid, flag_denorm;
    logic [127:0] mask;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    vec_fcmp_mask u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .opa          (opa),
        .opb          (opb),
        .pred         (pred),
        .out_valid    (out_valid),
        .mask         (mask),
        .flag_invalid (flag_invalid),
        .flag_denorm  (flag_denorm)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] m4(input bit b3, input bit b2, input bit b1, input bit b0);
        return {{32{b3}}, {32{b2}}, {32{b1}}, {32{b0}}};
    endfunction

    function automatic bit f_nan(input logic [31:0] w);
        return (w[30:23] == 8'hFF) && (w[22:0] != 0);
    endfunction

    function automatic bit f_qnan(input logic [31:0] w);
        return f_nan(w) && w[22];
    endfunction

    function automatic bit f_snan(input logic [31:0] w);
        return f_nan(w) && !w[22];
    endfunction

    function automatic bit f_den(input logic [31:0] w);
        return (w[30:23] == 0) && (w[22:0] != 0);
    endfunction

    // signed ordering key: both zeros map to 0
    function automatic longint f_key(input logic [31:0] w);
        longint m = longint'(w[30:0]);
        return w[31] ? -m : m;
    endfunction

    function automatic bit ref_lane(input logic [31:0] a, input logic [31:0] b, input logic [2:0] p);
        bit u = f_nan(a) || f_nan(b);
        longint ka = f_key(a);
        longint kb = f_key(b);
        case (p)
            3'd0: return !u && (ka == kb);
            3'd1: return !u && (ka <  kb);
            3'd2: return !u && (ka <= kb);
            3'd3: return u;
            3'd4: return u || (ka != kb);
            3'd5: return u || !(ka <  kb);
            3'd6: return u || !(ka <= kb);
            default: return !u;
        endcase
    endfunction

    function automatic logic [127:0] ref_mask(input logic [127:0] a, input logic [127:0] b, input logic [2:0] p);
        logic [127:0] r = '0;
        for (int l = 0; l < 4; l++)
            r[l*32 +: 32] = {32{ref_lane(a[l*32 +: 32], b[l*32 +: 32], p)}};
        return r;
    endfunction

    function automatic bit ref_inv(input logic [127:0] a, input logic [127:0] b, input logic [2:0] p);
        bit r = 1'b0;
        bit ord_p = (p == 3'd1) || (p == 3'd2) || (p == 3'd5) || (p == 3'd6);
        for (int l = 0; l < 4; l++) begin
            if (f_snan(a[l*32 +: 32]) || f_snan(b[l*32 +: 32])) r = 1'b1;
            if (ord_p && (f_qnan(a[l*32 +: 32]) || f_qnan(b[l*32 +: 32]))) r = 1'b1;
        end
        return r;
    endfunction

    function automatic bit ref_den(input logic [127:0] a, input logic [127:0] b);
        bit r = 1'b0;
        for (int l = 0; l < 4; l++)
            if (f_den(a[l*32 +: 32]) || f_den(b[l*32 +: 32])) r = 1'b1;
        return r;
    endfunction

    // apply one vector, sample one cycle later at the falling edge
    task automatic run_vec(input logic [127:0] a, input logic [127:0] b, input logic [2:0] p,
                           input logic [127:0] em, input bit ei, input bit ed, input string tag);
        @(negedge clk);
        opa = a; opb = b; pred = p; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " out_valid R9"}, {127'd0, out_valid}, 128'd1);
        chk({tag, " mask"}, mask, em);
        chk({tag, " flag_invalid R6/R7"}, {127'd0, flag_invalid}, {127'd0, ei});
        chk({tag, " flag_denorm R8"}, {127'd0, flag_denorm}, {127'd0, ed});
    endtask

    function automatic logic [31:0] pick_val();
        logic [31:0] r = $urandom;
        case ($urandom % 10)
            0: return PZ;
            1: return NZ;
            2: return {r[31], 8'hFF, 1'b1, r[21:0]};
            3: return {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
            4: return {r[31], 8'h00, r[22:1], 1'b1};
            5: return r[31] ? NINF : PINF;
            6: return {r[31], 8'h7F, r[22:0]};
            default: return r;
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [127:0] held;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset out_valid", {127'd0, out_valid}, '0);
        chk("R10 reset mask", mask, '0);
        chk("R10 reset flags", {126'd0, flag_invalid, flag_denorm}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        run_vec({PZ, NZ, ONE, ONE}, {NZ, PZ, ONE, TWO}, 3'd0, m4(1,1,1,0), 0, 0, "R2 EQ zeros");
        run_vec({NONE, ONE, NZ, NINF}, {ONE, NONE, PZ, NONE}, 3'd1, m4(1,0,0,1), 0, 0, "R3 LT signs");
        run_vec({NONE, ONE, NZ, NINF}, {ONE, NONE, PZ, NONE}, 3'd2, m4(1,0,1,1), 0, 0, "R3 LE signs");
        // greater-than by operand swap: x=(2,1,-1,inf) GT y=(1,2,-1,2)
        run_vec({ONE, TWO, NONE, TWO}, {TWO, ONE, NONE, PINF}, 3'd1, m4(1,0,0,1), 0, 0, "R3 GT swap");
        run_vec({QN, ONE, ONE, PZ}, {ONE, QN, ONE, NZ}, 3'd4, m4(1,1,0,0), 0, 0, "R4 NEQ nan");
        run_vec({QN, TWO, ONE, NONE}, {ONE, ONE, TWO, ONE}, 3'd5, m4(1,1,0,0), 1, 0, "R4 NLT nan");
        run_vec({QN, ONE, ONE, NONE}, {ONE, ONE, TWO, ONE}, 3'd6, m4(1,0,0,0), 1, 0, "R4 NLE nan");
        run_vec({QN, ONE, PINF, ONE}, {ONE, ONE, PINF, QN}, 3'd7, m4(0,1,1,0), 0, 0, "R5 ORD");
        run_vec({QN, ONE, PINF, ONE}, {ONE, ONE, PINF, QN}, 3'd3, m4(1,0,0,1), 0, 0, "R5 UNORD");
        run_vec({ONE, ONE, ONE, SN}, {ONE, ONE, ONE, ONE}, 3'd0, m4(1,1,1,0), 1, 0, "R6 snan EQ");
        run_vec({ONE, ONE, ONE, ONE}, {SN, ONE, ONE, ONE}, 3'd3, m4(1,0,0,0), 1, 0, "R6 snan UNORD");
        run_vec({QN, ONE, ONE, ONE}, {ONE, ONE, ONE, ONE}, 3'd0, m4(0,1,1,1), 0, 0, "R7 qnan EQ quiet");
        run_vec({QN, ONE, ONE, ONE}, {ONE, ONE, ONE, ONE}, 3'd2, m4(0,1,1,1), 1, 0, "R7 qnan LE");
        run_vec({NDEN, ONE, ONE, DEN}, {PZ, ONE, ONE, PZ}, 3'd1, m4(1,0,0,0), 0, 1, "R8 denorm LT");
        run_vec({ONE, TWO, NONE, PINF}, {ONE, ONE, NONE, PINF}, 3'd0, m4(1,0,1,1), 0, 0, "R1 lanes");

        // R9: idle cycle with changed inputs must not disturb outputs
        held = mask;
        @(negedge clk);
        opa = {4{SN}}; opb = {4{DEN}}; pred = 3'd4; in_valid = 1'b0;
        @(negedge clk);
        chk("R9 idle out_valid", {127'd0, out_valid}, '0);
        chk("R9 idle mask hold", mask, held);
        chk("R9 idle flags hold", {126'd0, flag_invalid, flag_denorm}, '0);

        // weighted random vectors
        for (int i = 0; i < 400; i++) begin
            logic [127:0] a, b;
            logic [2:0]   p;
            for (int l = 0; l < 4; l++) begin
                a[l*32 +: 32] = pick_val();
                case ($urandom % 4)
                    0: b[l*32 +: 32] = a[l*32 +: 32];
                    1: b[l*32 +: 32] = a[l*32 +: 32] ^ 32'h8000_0000;
                    default: b[l*32 +: 32] = pick_val();
                endcase
            end
            p = 3'($urandom);
            run_vec(a, b, p, ref_mask(a, b, p), ref_inv(a, b, p), ref_den(a, b), "R1 random");
        end

        // R10: reset mid-stream clears captured results
        @(negedge clk);
        opa = {4{ONE}}; opb = {4{ONE}}; pred = 3'd0; in_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 reset clears mask", mask, '0);
        chk("R10 reset clears valid", {127'd0, out_valid}, '0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule